// File: doc/BRIEF.md
# E1 Signaling Multiframe Aligner

This block finds and then follows the 16-frame channel-associated-signaling (CAS) multiframe carried in timeslot 16 of an E1 stream. Its input is an octet bus that is already aligned to basic frames. A strobe marks the start of each basic frame, and a second strobe marks the one octet that is timeslot 16. Octet bit 7 is the first bit on the line. The block only hunts when the basic framer reports sync and the CAS enable input is high.

Once aligned, the block reports where each frame sits inside the multiframe. From frame 0 it extracts the remote multiframe alarm bit and the three spare bits. In frames 1 to 15 it hands out the two ABCD signaling codewords, each tagged with the voice timeslot it belongs to. Each frame-0 octet that breaks the alignment pattern produces an error pulse. After a run of such errors, alignment is dropped and the hunt starts again.

Top module: `casmf_align`

## Requirements
- R1: After reset, oos_o=1, mf_pos_o=0, rmai_o=0, xbits_o=0, sig_vld_o=0 and pat_err_o=0.
- R2: The hunt runs only while frame_sync_i and cas_en_i are both 1. If either is 0 during a timeslot-16 strobe, oos_o is 1 afterwards and the memory of the prior nibble is wiped.
- R3: Alignment needs two consecutive timeslot-16 octets. The earlier one has a nonzero upper nibble (bits 7:4). The later one has upper nibble 0000. oos_o falls one cycle after the later octet's strobe, and that frame is multiframe position 0.
- R4: While aligned, mf_pos_o rises by one on each frame strobe and wraps from 15 to 0. While out of alignment it reads 0.
- R5: The frame-0 octet is laid out as 0000 X0 Y X1 X2 from bit 7 down. On every frame 0 whose upper nibble is 0000 while aligned (including the aligning frame), rmai_o takes bit 2 and xbits_o takes {bit 3, bit 1, bit 0}, one cycle after the strobe. Otherwise both hold their values.
- R6: While aligned, a strobe in frame n (1..15) gives a one-cycle sig_vld_o pulse on the next cycle. On that pulse, sig_hi_o carries bits 7:4 with sig_hi_ts_o=n, and sig_lo_o carries bits 3:0 with sig_lo_ts_o=n+16.
- R7: sig_vld_o stays 0 for strobes seen while out of alignment and for the frame-0 strobe.
- R8: While aligned, a frame-0 upper nibble other than 0000 gives exactly one pat_err_o pulse, one cycle after the strobe.
- R9: Alignment is lost (oos_o=1) after LOSS_CNT (default 2) consecutive erred frame-0 octets. A clean frame 0 in between clears the run.
- R10: The octet that causes the loss also counts as the prior nibble for the new hunt. So a 0000 nibble in the very next frame realigns at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oct_i | input | 8 | Received octet, bit 7 first on the line |
| frm_stb_i | input | 1 | Start of a basic frame |
| ts16_stb_i | input | 1 | oct_i holds timeslot 16 (never together with frm_stb_i) |
| frame_sync_i | input | 1 | Basic frame alignment is held |
| cas_en_i | input | 1 | Enables the signaling multiframe hunt |
| oos_o | output | 1 | Out of multiframe alignment |
| mf_pos_o | output | 4 | Frame position within the multiframe |
| rmai_o | output | 1 | Remote multiframe alarm bit |
| xbits_o | output | 3 | Spare bits {X0,X1,X2} |
| pat_err_o | output | 1 | Frame-0 pattern error pulse |
| sig_vld_o | output | 1 | Signaling pair valid pulse |
| sig_hi_o | output | 4 | ABCD for timeslot sig_hi_ts_o |
| sig_hi_ts_o | output | 5 | Timeslot of sig_hi_o (1..15) |
| sig_lo_o | output | 4 | ABCD for timeslot sig_lo_ts_o |
| sig_lo_ts_o | output | 5 | Timeslot of sig_lo_o (17..31) |

## Verification
A wrong lock or miss-count state shows up on oos_o one cycle after the timeslot-16 strobe that should have changed it. A wrong position shows up within one frame, as wrong timeslot tags on sig_hi_ts_o and sig_lo_ts_o, or as a misplaced pat_err_o, because the next frame-0 comparison lands on a signaling octet. Stale spare or alarm bits only become visible on the next clean frame 0, so a fault there can hide for up to a full multiframe. The stimulus therefore includes phase slips, isolated errors and drops of the qualifiers, so that each of these states is disturbed and then observed.

// File: rtl/casmf_pkg.sv
package casmf_pkg;
   localparam int OCT_W     = 8;
   localparam int NIB_W     = 4;
   localparam int MF_FRAMES = 16;
   localparam int POS_W     = $clog2(MF_FRAMES);
   localparam int TS_W      = POS_W + 1;

   typedef struct packed {
      logic [NIB_W-1:0] hi;
      logic [TS_W-1:0]  hi_ts;
      logic [NIB_W-1:0] lo;
      logic [TS_W-1:0]  lo_ts;
   } sig_pair_t;

   function automatic logic [NIB_W-1:0] upper_nib(input logic [OCT_W-1:0] o);
      return o[OCT_W-1 -: NIB_W];
   endfunction

   function automatic logic [2:0] spare_of(input logic [OCT_W-1:0] o);
      return {o[3], o[1], o[0]};
   endfunction
endpackage

// File: rtl/casmf_hunt.sv
module casmf_hunt
   import casmf_pkg::*;
#(
   parameter int LOSS_CNT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_i,
   input  logic             ts16_i,
   input  logic [NIB_W-1:0] nib_i,
   input  logic             pos_zero_i,
   output logic             lock_o,
   output logic             align_o,
   output logic             f0_ok_o,
   output logic             perr_o
);
   logic lock_q, prev_nz_q, perr_q;
   logic ev, nib_zero, f0_err, f0_ok, lose;

   assign ev       = gate_i & ts16_i;
   assign nib_zero = (nib_i == '0);
   assign align_o  = ev & ~lock_q & nib_zero & prev_nz_q;
   assign f0_err   = ev & lock_q & pos_zero_i & ~nib_zero;
   assign f0_ok    = ev & lock_q & pos_zero_i & nib_zero;

   generate
      if (LOSS_CNT == 1) begin : g_single
         assign lose = f0_err;
      end else begin : g_count
         localparam int MISS_W = $clog2(LOSS_CNT);
         logic [MISS_W-1:0] miss_q;
         assign lose = f0_err && (miss_q == MISS_W'(LOSS_CNT - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)
               miss_q <= '0;
            else if (!gate_i || align_o || f0_ok || lose)
               miss_q <= '0;
            else if (f0_err)
               miss_q <= miss_q + 1'b1;
         end
         p_miss_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
            miss_q <= MISS_W'(LOSS_CNT - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q    <= 1'b0;
         prev_nz_q <= 1'b0;
         perr_q    <= 1'b0;
      end else begin
         perr_q <= f0_err;
         if (!gate_i) begin
            lock_q    <= 1'b0;
            prev_nz_q <= 1'b0;
         end else begin
            if (ts16_i) prev_nz_q <= ~nib_zero;
            if (align_o)   lock_q <= 1'b1;
            else if (lose) lock_q <= 1'b0;
         end
      end
   end

   assign lock_o  = lock_q;
   assign f0_ok_o = f0_ok;
   assign perr_o  = perr_q;

   p_gate_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_i |=> !lock_q);
   p_align_prev_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> ($past(nib_i) == '0) && $past(prev_nz_q) && $past(ts16_i));
   p_perr_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      perr_q |-> $past(lock_q) && $past(pos_zero_i));
endmodule

// File: rtl/casmf_pos.sv
module casmf_pos
   import casmf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_i,
   input  logic             align_i,
   input  logic             frm_stb_i,
   output logic [POS_W-1:0] pos_o
);
   logic [POS_W-1:0] pos_q;

   generate
      if (MF_FRAMES != (1 << POS_W)) begin : g_bad_len
         $error("multiframe length must be a power of two");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         pos_q <= '0;
      else if (align_i || !lock_i)
         pos_q <= '0;
      else if (frm_stb_i)
         pos_q <= pos_q + 1'b1;
   end

   assign pos_o = pos_q;

   p_pos_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_i && $past(lock_i) && $past(frm_stb_i) && !$past(align_i))
         |-> pos_q == POS_W'($past(pos_q) + 1));
   p_pos_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_i && !$past(lock_i)) |-> pos_q == '0);
endmodule

// File: rtl/casmf_sigmap.sv
module casmf_sigmap
   import casmf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_i,
   input  logic             lock_i,
   input  logic             align_i,
   input  logic             f0_ok_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic [OCT_W-1:0] oct_i,
   output logic             rmai_o,
   output logic [2:0]       spare_o,
   output logic             vld_o,
   output sig_pair_t        pair_o
);
   logic      rmai_q, vld_q, fire, take_f0;
   logic [2:0] spare_q;
   sig_pair_t pair_q;

   assign take_f0 = align_i | f0_ok_i;
   assign fire    = ev_i & lock_i & (pos_i != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rmai_q  <= 1'b0;
         spare_q <= '0;
         vld_q   <= 1'b0;
         pair_q  <= '0;
      end else begin
         vld_q <= fire;
         if (take_f0) begin
            rmai_q  <= oct_i[2];
            spare_q <= spare_of(oct_i);
         end
         if (fire) begin
            pair_q.hi    <= upper_nib(oct_i);
            pair_q.lo    <= oct_i[NIB_W-1:0];
            pair_q.hi_ts <= {1'b0, pos_i};
            pair_q.lo_ts <= {1'b1, pos_i};
         end
      end
   end

   assign rmai_o  = rmai_q;
   assign spare_o = spare_q;
   assign vld_o   = vld_q;
   assign pair_o  = pair_q;

   p_no_sig_oos_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> $past(lock_i) && ($past(pos_i) != '0));
   p_sig_ts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> (pair_q.hi_ts != '0) && (pair_q.lo_ts == pair_q.hi_ts + TS_W'(MF_FRAMES)));
endmodule

// File: rtl/casmf_align.sv
module casmf_align
   import casmf_pkg::*;
#(
   parameter int LOSS_CNT = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] oct_i,
   input  logic       frm_stb_i,
   input  logic       ts16_stb_i,
   input  logic       frame_sync_i,
   input  logic       cas_en_i,
   output logic       oos_o,
   output logic [3:0] mf_pos_o,
   output logic       rmai_o,
   output logic [2:0] xbits_o,
   output logic       pat_err_o,
   output logic       sig_vld_o,
   output logic [3:0] sig_hi_o,
   output logic [4:0] sig_hi_ts_o,
   output logic [3:0] sig_lo_o,
   output logic [4:0] sig_lo_ts_o
);
   generate
      if (LOSS_CNT < 1 || LOSS_CNT > 16) begin : g_bad_loss
         $error("LOSS_CNT out of range");
      end
   endgenerate

   logic             gate, lock, align, f0_ok;
   logic [POS_W-1:0] pos;
   sig_pair_t        pair;

   assign gate = frame_sync_i & cas_en_i;

   casmf_hunt #(.LOSS_CNT(LOSS_CNT)) hunt_i (
      .clk(clk), .rst_n(rst_n), .gate_i(gate), .ts16_i(ts16_stb_i),
      .nib_i(upper_nib(oct_i)), .pos_zero_i(pos == '0),
      .lock_o(lock), .align_o(align), .f0_ok_o(f0_ok), .perr_o(pat_err_o)
   );

   casmf_pos pos_i (
      .clk(clk), .rst_n(rst_n), .lock_i(lock), .align_i(align),
      .frm_stb_i(frm_stb_i), .pos_o(pos)
   );

   casmf_sigmap map_i (
      .clk(clk), .rst_n(rst_n), .ev_i(gate & ts16_stb_i), .lock_i(lock),
      .align_i(align), .f0_ok_i(f0_ok), .pos_i(pos), .oct_i(oct_i),
      .rmai_o(rmai_o), .spare_o(xbits_o), .vld_o(sig_vld_o), .pair_o(pair)
   );

   assign oos_o       = ~lock;
   assign mf_pos_o    = pos;
   assign sig_hi_o    = pair.hi;
   assign sig_hi_ts_o = pair.hi_ts;
   assign sig_lo_o    = pair.lo;
   assign sig_lo_ts_o = pair.lo_ts;

   p_err_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pat_err_o |=> !pat_err_o);
endmodule

// File: tb/casmf_align_tb.sv
`timescale 1ns/1ps
module casmf_align_tb_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [7:0] oct = '0;
   logic frm_stb = 0, ts16 = 0, fsync = 0, casen = 0;
   logic oos, rmai, perr, svld;
   logic [3:0] mpos, shi, slo;
   logic [2:0] xb;
   logic [4:0] shts, slts;

   int n_chk = 0, n_err = 0;

   // bench model state
   logic       m_lock = 0, m_prev = 0, m_rmai = 0;
   int         m_pos = 0, m_miss = 0;
   logic [2:0] m_x = '0;
   int         tx_pos = 0;

   always #2.5 clk = ~clk;

   casmf_align dut_i (
      .clk(clk), .rst_n(rst_n), .oct_i(oct), .frm_stb_i(frm_stb),
      .ts16_stb_i(ts16), .frame_sync_i(fsync), .cas_en_i(casen),
      .oos_o(oos), .mf_pos_o(mpos), .rmai_o(rmai), .xbits_o(xb),
      .pat_err_o(perr), .sig_vld_o(svld), .sig_hi_o(shi), .sig_hi_ts_o(shts),
      .sig_lo_o(slo), .sig_lo_ts_o(slts)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] gen_oct(input int p);
      logic [7:0] o;
      o[3:0] = 4'($urandom_range(0, 15));
      o[7:4] = (p == 0) ? 4'h0 : 4'($urandom_range(1, 15));
      return o;
   endfunction

   task automatic run_frame(input logic [7:0] o, input logic s, input logic e);
      logic e_vld, e_perr;
      logic [3:0] hi;
      @(negedge clk); fsync = s; casen = e;
      @(negedge clk); frm_stb = 1;
      @(negedge clk); frm_stb = 0;
      @(negedge clk); ts16 = 1; oct = o;
      @(negedge clk); ts16 = 0;
      e_vld = 0; e_perr = 0; hi = o[7:4];
      if (!(s && e)) begin
         m_lock = 0; m_prev = 0; m_miss = 0; m_pos = 0;
      end else begin
         m_pos = m_lock ? (m_pos + 1) % 16 : 0;
         if (!m_lock) begin
            if (hi == 0 && m_prev) begin
               m_lock = 1; m_pos = 0; m_miss = 0;
               m_rmai = o[2]; m_x = {o[3], o[1], o[0]};
            end
         end else if (m_pos == 0) begin
            if (hi != 0) begin
               e_perr = 1; m_miss++;
               if (m_miss == 2) begin m_lock = 0; m_miss = 0; end
            end else begin
               m_miss = 0; m_rmai = o[2]; m_x = {o[3], o[1], o[0]};
            end
         end else e_vld = 1;
         m_prev = (hi != 0);
      end
      chk("R3 oos", 32'(oos), 32'(!m_lock));
      chk("R4 pos", 32'(mpos), 32'(m_pos));
      chk("R7 sig_vld", 32'(svld), 32'(e_vld));
      chk("R8 pat_err", 32'(perr), 32'(e_perr));
      chk("R5 rmai", 32'(rmai), 32'(m_rmai));
      chk("R5 xbits", 32'(xb), 32'(m_x));
      if (e_vld) begin
         chk("R6 hi", 32'(shi), 32'(hi));
         chk("R6 lo", 32'(slo), 32'(o[3:0]));
         chk("R6 hi_ts", 32'(shts), 32'(m_pos));
         chk("R6 lo_ts", 32'(slts), 32'(m_pos + 16));
      end
      @(negedge clk);
      chk("R6 pulse", 32'(svld), 32'd0);
      chk("R8 pulse", 32'(perr), 32'd0);
   endtask

   task automatic tx_frame(input logic s, input logic e);
      run_frame(gen_oct(tx_pos), s, e);
      tx_pos = (tx_pos + 1) % 16;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset values
      chk("R1 oos", 32'(oos), 32'd1);
      chk("R1 pos", 32'(mpos), 32'd0);
      chk("R1 rmai/x", 32'({rmai, xb}), 32'd0);
      chk("R1 pulses", 32'({svld, perr}), 32'd0);

      // R2: enable off, framed pattern present: no alignment
      for (int i = 0; i < 20; i++) tx_frame(1'b1, 1'b0);
      chk("R2 no hunt without enable", 32'(oos), 32'd1);

      // R3: zero nibble with zero prior does not align
      run_frame(8'h05, 1, 1);
      run_frame(8'h0A, 1, 1);
      chk("R3 zero after zero", 32'(oos), 32'd1);
      run_frame(8'h93, 1, 1);
      run_frame(8'h04, 1, 1);   // Y=1, X0=0,X1=0,X2=0
      chk("R3 aligned", 32'(oos), 32'd0);
      chk("R5 rmai from frame0", 32'(rmai), 32'd1);
      tx_pos = 1;

      // R4 wrap and R6 timeslot 15/31
      for (int i = 0; i < 40; i++) tx_frame(1, 1);

      // R9 single error does not lose alignment
      while (tx_pos != 0) tx_frame(1, 1);
      run_frame(8'h4B, 1, 1); tx_pos = 1;
      chk("R9 one error kept", 32'(oos), 32'd0);
      for (int i = 0; i < 15; i++) tx_frame(1, 1);
      run_frame(8'h0B, 1, 1); tx_pos = 1;   // X0=1,Y=0,X1=1,X2=1
      chk("R5 xbits", 32'(xb), 32'h7);
      for (int i = 0; i < 15; i++) tx_frame(1, 1);
      run_frame(8'h10, 1, 1); tx_pos = 1;
      for (int i = 0; i < 15; i++) tx_frame(1, 1);
      run_frame(8'h20, 1, 1);
      chk("R9 two errors lost", 32'(oos), 32'd1);
      // R10: next zero nibble realigns at once
      run_frame(8'h02, 1, 1); tx_pos = 1;
      chk("R10 immediate realign", 32'(oos), 32'd0);
      for (int i = 0; i < 5; i++) tx_frame(1, 1);

      // R2 loss of basic sync drops alignment
      tx_frame(0, 1);
      chk("R2 sync drop", 32'(oos), 32'd1);
      chk("R4 pos cleared", 32'(mpos), 32'd0);

      // random phase
      for (int i = 0; i < 2500; i++) begin
         int r;
         logic s, e;
         logic [7:0] o;
         r = $urandom_range(0, 99);
         s = (r >= 2);
         e = (r != 2);
         if ($urandom_range(0, 199) == 0) tx_pos = $urandom_range(0, 15);
         o = gen_oct(tx_pos);
         if (tx_pos == 0 && $urandom_range(0, 7) == 0) o[7:4] = 4'($urandom_range(1, 15));
         run_frame(o, s, e);
         tx_pos = (tx_pos + 1) % 16;
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule